// File: doc/BRIEF.md
# Programmable Word-Length Video Output Clipper

This block sits at the end of a video sample pipeline. It takes a signed 18-bit sample and saturates it to one of four output word lengths: 8, 10, 12 or 16 bits. The clip range can be unipolar, which is unsigned and starts at zero, or bipolar, which is two's complement and centred on zero. The result goes out on a 16-bit bus through one register stage. An over-range flag is raised when the sample lies above the upper clip level. The top bit of the bus reports an under-range condition in every mode except 16-bit bipolar, where that bit carries the sign of the data.

The word length and the clip mode are configuration inputs. They are normally held static by a register bank outside the block, and they are sampled on the same edge as the data. Logically the block has a single state, IDLE_HOLD, in which the output register keeps its contents. A LOAD transition occurs on each cycle with a valid input strobe and returns to IDLE_HOLD, so it needs no state register of its own.

Top module: `vid_word_clip`

## Requirements
- R1: `wlen_sel` picks the word length N: 2'b00 gives 8, 2'b01 gives 10, 2'b10 gives 12 and 2'b11 gives 16. Output bits 14 down to N are always zero.
- R2: When `bipolar_en` is 0, the sample is limited to the range 0 to 2^N-1. The limited value appears unsigned on `clip_out[N-1:0]`.
- R3: When `bipolar_en` is 1, the sample is limited to the range -2^(N-1) to 2^(N-1)-1. The limited value appears in N-bit two's complement on `clip_out[N-1:0]`.
- R4: `over_flag` is 1 exactly when the sample is greater than the upper clip level of the selected mode.
- R5: For N of 8, 10 or 12, in either clip mode, `clip_out[15]` is 1 exactly when the sample is below the lower clip level.
- R6: In 16-bit unipolar mode, `clip_out[15]` is the OR of data bit 15 and the under-range condition. A negative sample therefore gives 16'h8000.
- R7: In 16-bit bipolar mode, `clip_out[15]` is the sign bit of the limited value, and no under-range flag is merged into it.
- R8: A sample taken with `smp_vld` high appears on the outputs one clock later, with `out_vld` high. In a cycle without `smp_vld`, `clip_out` and `over_flag` keep their values and `out_vld` is 0.
- R9: While `rst_n` is low, `clip_out`, `over_flag` and `out_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Input sample strobe |
| smp_in | input | 18 | Signed input sample (two's complement) |
| wlen_sel | input | 2 | Output word length select |
| bipolar_en | input | 1 | 1 selects bipolar clipping, 0 selects unipolar |
| out_vld | output | 1 | Registered sample strobe |
| clip_out | output | 16 | Clipped output word with the under-range flag in bit 15 |
| over_flag | output | 1 | Over-range flag |

## Verification
Two functions can act in the same cycle: saturation of the data field and the under-range marker on bit 15. This happens whenever a sample lies below the lower limit. In 16-bit unipolar mode both functions also compete for the same bit. The bench provokes the overlap by sweeping inputs that straddle each lower and upper limit, in all eight combinations of word length and clip mode. For every such sample it checks the whole 16-bit word against an arithmetic model: the limited data bits, the zeroed upper bits and the flag bit.

// File: rtl/vid_clip_pkg.sv
package vid_clip_pkg;

    localparam int SMP_W  = 18;
    localparam int WORD_W = 16;
    localparam int NB_W   = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        WLEN_8  = 2'b00,
        WLEN_10 = 2'b01,
        WLEN_12 = 2'b10,
        WLEN_16 = 2'b11
    } wlen_e;

    typedef enum logic {
        IDLE_HOLD = 1'b0,
        LOAD      = 1'b1
    } ostage_e;

endpackage

// File: rtl/vid_clip_limits.sv
module vid_clip_limits
    import vid_clip_pkg::*;
#(
    parameter int SW = SMP_W,
    parameter int WW = WORD_W
) (
    input  wlen_e                 wlen,
    input  logic                  bipolar,
    output logic signed [SW-1:0]  lim_hi,
    output logic signed [SW-1:0]  lim_lo,
    output logic [WW-1:0]         data_mask,
    output logic                  flag_en
);

    localparam logic [SW-1:0] ONE = {{(SW-1){1'b0}}, 1'b1};

    logic [NB_W-1:0] n_bits;
    logic [SW-1:0]   span;
    logic [SW-1:0]   half;

    always_comb begin
        unique case (wlen)
            WLEN_8:  n_bits = NB_W'(8);
            WLEN_10: n_bits = NB_W'(10);
            WLEN_12: n_bits = NB_W'(12);
            WLEN_16: n_bits = NB_W'(16);
            default: n_bits = NB_W'(16);
        endcase
        span = ONE << n_bits;
        half = span >> 1;
        if (bipolar) begin
            lim_hi = $signed(half - ONE);
            lim_lo = $signed(-half);
        end else begin
            lim_hi = $signed(span - ONE);
            lim_lo = '0;
        end
        data_mask = WW'(span - ONE);
        flag_en   = !(bipolar && (wlen == WLEN_16));
    end

endmodule

// File: rtl/vid_clip_sat.sv
module vid_clip_sat
    import vid_clip_pkg::*;
#(
    parameter int SW = SMP_W,
    parameter int WW = WORD_W
) (
    input  logic signed [SW-1:0]  smp,
    input  logic signed [SW-1:0]  lim_hi,
    input  logic signed [SW-1:0]  lim_lo,
    input  logic [WW-1:0]         data_mask,
    input  logic                  flag_en,
    output logic [WW-1:0]         word,
    output logic                  above,
    output logic                  below
);

    logic signed [SW-1:0] lim_val;
    logic [WW-1:0]        masked;

    always_comb begin
        above = (smp > lim_hi);
        below = (smp < lim_lo);
        if (above)
            lim_val = lim_hi;
        else if (below)
            lim_val = lim_lo;
        else
            lim_val = smp;
    end

    // Bits below the top one: value bit gated by the word-length mask
    for (genvar b = 0; b < WW - 1; b++) begin : g_low
        assign masked[b] = lim_val[b] & data_mask[b];
    end
    // Top bit: data (16-bit modes only) merged with the under-range marker
    assign masked[WW-1] = (lim_val[WW-1] & data_mask[WW-1]) | (below & flag_en);

    assign word = masked;

endmodule

// File: rtl/vid_word_clip.sv
module vid_word_clip
    import vid_clip_pkg::*;
#(
    parameter int SW = SMP_W,
    parameter int WW = WORD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld,
    input  logic [SW-1:0]  smp_in,
    input  logic [1:0]     wlen_sel,
    input  logic           bipolar_en,
    output logic           out_vld,
    output logic [WW-1:0]  clip_out,
    output logic           over_flag
);

    logic signed [SW-1:0] lim_hi;
    logic signed [SW-1:0] lim_lo;
    logic [WW-1:0]        data_mask;
    logic                 flag_en;
    logic [WW-1:0]        word_nxt;
    logic                 above;
    logic                 below;
    ostage_e              ostage;

    vid_clip_limits #(.SW(SW), .WW(WW)) u_lim (
        .wlen      (wlen_e'(wlen_sel)),
        .bipolar   (bipolar_en),
        .lim_hi    (lim_hi),
        .lim_lo    (lim_lo),
        .data_mask (data_mask),
        .flag_en   (flag_en)
    );

    vid_clip_sat #(.SW(SW), .WW(WW)) u_sat (
        .smp       ($signed(smp_in)),
        .lim_hi    (lim_hi),
        .lim_lo    (lim_lo),
        .data_mask (data_mask),
        .flag_en   (flag_en),
        .word      (word_nxt),
        .above     (above),
        .below     (below)
    );

    assign ostage = smp_vld ? LOAD : IDLE_HOLD;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            clip_out  <= '0;
            over_flag <= 1'b0;
        end else begin
            out_vld <= (ostage == LOAD);
            unique case (ostage)
                LOAD: begin
                    clip_out  <= word_nxt;
                    over_flag <= above;
                end
                IDLE_HOLD: begin
                    clip_out  <= clip_out;
                    over_flag <= over_flag;
                end
                default: begin
                    clip_out  <= clip_out;
                    over_flag <= over_flag;
                end
            endcase
        end
    end

    // R8
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> out_vld);

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> (!out_vld && $stable(clip_out) && $stable(over_flag)));

    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && wlen_sel == 2'b00) |=> (clip_out[14:8] == 7'd0));

    // R4
    over_8u_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && wlen_sel == 2'b00 && !bipolar_en && $signed(smp_in) > 18'sd255)
        |=> (over_flag && clip_out[7:0] == 8'hFF && !clip_out[15]));

    // R5
    under_uni_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !bipolar_en && smp_in[SW-1])
        |=> (!over_flag && clip_out == 16'h8000));

    // R7
    sign_bip16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && wlen_sel == 2'b11 && bipolar_en && $signed(smp_in) < -18'sd32768)
        |=> (!over_flag && clip_out == 16'h8000));

    // R5
    no_under_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !smp_in[SW-1] && wlen_sel != 2'b11) |=> !clip_out[15]);

endmodule

// File: tb/vid_word_clip_test.sv
module vid_word_clip_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [17:0] smp_in = '0;
    logic [1:0]  wlen_sel = 2'b00;
    logic        bipolar_en = 1'b0;
    logic        out_vld;
    logic [15:0] clip_out;
    logic        over_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vid_word_clip uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld    (smp_vld),
        .smp_in     (smp_in),
        .wlen_sel   (wlen_sel),
        .bipolar_en (bipolar_en),
        .out_vld    (out_vld),
        .clip_out   (clip_out),
        .over_flag  (over_flag)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int nbits(input int sel);
        case (sel)
            0: return 8;
            1: return 10;
            2: return 12;
            default: return 16;
        endcase
    endfunction

    task automatic apply(input int v, input bit idle_check);
        int n, hi, lo, y, expw, m;
        bit ov, un;
        string dtag;
        logic [15:0] prev;
        n  = nbits(int'(wlen_sel));
        hi = bipolar_en ? (1 << (n - 1)) - 1 : (1 << n) - 1;
        lo = bipolar_en ? -(1 << (n - 1)) : 0;
        ov = v > hi;
        un = v < lo;
        y  = ov ? hi : (un ? lo : v);
        m  = (1 << n) - 1;
        expw = y & m;
        if (!(n == 16 && bipolar_en)) expw = expw | (un ? 32'h8000 : 0);
        if (n == 16 && !bipolar_en)  dtag = "R6";
        else if (n == 16)            dtag = "R7";
        else if (un)                 dtag = "R5";
        else if (bipolar_en)         dtag = "R3";
        else                         dtag = "R2";

        @(negedge clk);
        smp_in  = v[17:0];
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        chk(int'(clip_out) == expw, dtag, "word", int'(clip_out), expw);
        chk(over_flag == ov, "R4", "over_flag", int'(over_flag), int'(ov));
        chk(out_vld == 1'b1, "R8", "out_vld", int'(out_vld), 1);
        chk((clip_out & 16'h7FFF & ~m[15:0]) == 16'h0, "R1", "upper bits",
            int'(clip_out), expw);
        if (idle_check) begin
            prev = clip_out;
            smp_in = ~smp_in;
            @(negedge clk);
            chk(clip_out == prev && over_flag == ov && !out_vld, "R8", "idle hold",
                int'(clip_out), int'(prev));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(clip_out == 16'h0 && !over_flag && !out_vld, "R9", "reset state",
            int'({over_flag, out_vld, clip_out}), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++) begin
            int n, hi, lo;
            int edges[12];
            wlen_sel   = c[1:0];
            bipolar_en = c[2];
            n  = nbits(c & 3);
            hi = bipolar_en ? (1 << (n - 1)) - 1 : (1 << n) - 1;
            lo = bipolar_en ? -(1 << (n - 1)) : 0;
            edges = '{lo - 2, lo - 1, lo, lo + 1, hi - 1, hi, hi + 1, hi + 2,
                      0, -1, -131072, 131071};
            for (int e = 0; e < 12; e++) apply(edges[e], 1'b1);
            for (int v = -131072; v < 131072; v += 997) apply(v, 1'b0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule